// File: doc/BRIEF.md
# Serial Port Register Front End with Prioritised Interrupt

This block is the software-visible side of a 16550-style serial port. A word-addressed 32-bit register bus on one side configures the port and reads its status. Byte-wide receive and transmit stream interfaces on the other side connect to a bit shifter, which lies outside the block. Received bytes land in a single holding register; there is no FIFO. A byte written to the data register is sent straight out on the transmit stream.

The receiver reports parity errors, framing errors and break conditions to the block as one-cycle strobes. These collect in sticky line status bits. Eight modem status lines are passed through for reading, and their low four (delta) bits can raise an interrupt. A fixed priority picks one pending, enabled source, reports it as a three-bit identification code, and drives a registered level interrupt.

Top module: `serial_ctrl_front`

## Requirements
- R1: Registers are selected by byte address bits 7:2. Word 0 is data, 1 interrupt enable, 2 ident, 3 line control, 4 modem control, 5 line status, 6 modem status and 7 divisor. Reads of interrupt enable, line control, modem control, divisor and any word 8 or above return zero. Writes to ident, line status, modem status and any word 8 or above change nothing.
- R2: After reset, line status reads 0x60 and ident reads 0x1. The interrupt is low, rx_ready is high, tx_valid is low, and all configuration outputs are zero.
- R3: Reading word 0 returns the held byte in bits 7:0 and clears data ready. rx_ready is high exactly while data ready is clear.
- R4: Any cycle with rx_valid high stores rx_byte and sets data ready. It also sets overrun if data ready was already set and word 0 is not being read in that same cycle.
- R5: Line status bits are: bit0 data ready, bit1 overrun, bit2 parity error, bit3 framing error, bit4 break, bit5 transmit holding empty and bit6 transmitter empty. Bits 5 and 6 always read 1. Bits 1 to 4 are sticky and are cleared by a line status read. A strobe arriving in the same cycle as that read wins, and the read itself returns the old value.
- R6: Interrupt enable bits are bit0 receive data, bit1 transmit empty, bit2 line status and bit3 modem. The ident code is 0b110 if any of bits 1 to 4 of line status is set and enable bit2 is set. Failing that, it is 0b100 for data ready with bit0, 0b010 for transmit empty with bit1, and 0b000 for any of modem lines 3:0 with bit3. Otherwise it is 0b001.
- R7: irq is high exactly when the ident code computed from the register state one clock earlier differs from 0b001.
- R8: A write to word 0 makes tx_valid high for the following cycle only, with tx_byte holding write data bits 7:0.
- R9: Writes to line control (bits 7:0), modem control (bits 1:0) and divisor (bits DIV_W-1:0) appear on line_ctrl, modem_ctrl and divisor from the next cycle.
- R10: Reading word 6 returns modem_lines in bits 7:0. Modem lines 7:4 never raise an interrupt.
- R11: Every read gives rsp_valid and rsp_rdata in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address (bits 1:0 ignored) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | BYTE_W | Received byte |
| rx_ready | output | 1 | Holding register empty |
| rx_parity_err | input | 1 | Parity error strobe |
| rx_frame_err | input | 1 | Framing error strobe |
| rx_break | input | 1 | Break strobe |
| modem_lines | input | 8 | Modem status inputs; bits 3:0 are deltas |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | BYTE_W | Transmit byte |
| line_ctrl | output | 8 | Line control setting |
| modem_ctrl | output | 2 | Modem control setting |
| divisor | output | DIV_W | Baud divisor setting |
| irq | output | 1 | Level interrupt |

## Verification
A bus request or stream strobe sampled at a rising edge shows up after that same edge. This covers read data, tx_valid, rx_ready, configuration outputs and line status. irq follows one edge later, because it is registered from the state left by the earlier edge. The reference model applies each stimulus at the same rising edge as the design, carries the one-edge irq lag explicitly, and compares all outputs at the falling edge. Directed checks drive inputs on a falling edge and read results on the next falling edge. They wait two cycles before looking at irq.

// File: rtl/scf_pkg.sv
package scf_pkg;
    localparam int unsigned REG_COUNT = 8;
    localparam int unsigned IEN_W     = 4;
    localparam int unsigned LCTL_W    = 8;
    localparam int unsigned MCTL_W    = 2;
    localparam int unsigned MLINE_W   = 8;
    localparam int unsigned ID_W      = 3;

    typedef enum logic [2:0] {
        RG_DATA  = 3'd0,
        RG_IEN   = 3'd1,
        RG_IDENT = 3'd2,
        RG_LCTL  = 3'd3,
        RG_MCTL  = 3'd4,
        RG_LSTAT = 3'd5,
        RG_MSTAT = 3'd6,
        RG_DIV   = 3'd7
    } reg_sel_e;

    localparam logic [ID_W-1:0] ID_NONE  = 3'b001;
    localparam logic [ID_W-1:0] ID_LINE  = 3'b110;
    localparam logic [ID_W-1:0] ID_RXD   = 3'b100;
    localparam logic [ID_W-1:0] ID_THR   = 3'b010;
    localparam logic [ID_W-1:0] ID_MODEM = 3'b000;

    typedef struct packed {
        logic dr;
        logic oe;
        logic pe;
        logic fe;
        logic bi;
    } rx_stat_t;
endpackage

// File: rtl/scf_rx_hold.sv
module scf_rx_hold
    import scf_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              take_data,
    input  logic              take_stat,
    input  logic              pe_stb,
    input  logic              fe_stb,
    input  logic              bi_stb,
    output logic [BYTE_W-1:0] hold_o,
    output rx_stat_t          stat_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] hold;
        rx_stat_t          st;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_data) st_d.st.dr = 1'b0;
        if (take_stat) begin
            st_d.st.oe = 1'b0;
            st_d.st.pe = 1'b0;
            st_d.st.fe = 1'b0;
            st_d.st.bi = 1'b0;
        end
        if (rx_valid) begin
            if (st_q.st.dr && !take_data) st_d.st.oe = 1'b1;
            st_d.st.dr = 1'b1;
            st_d.hold  = rx_byte;
        end
        if (pe_stb) st_d.st.pe = 1'b1;
        if (fe_stb) st_d.st.fe = 1'b1;
        if (bi_stb) st_d.st.bi = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;
    assign stat_o = st_q.st;
endmodule

// File: rtl/scf_irq_prio.sv
module scf_irq_prio
    import scf_pkg::*;
(
    input  logic [IEN_W-1:0] ien,
    input  rx_stat_t         stat,
    input  logic             thr_empty,
    input  logic [3:0]       modem_delta,
    output logic [ID_W-1:0]  ident,
    output logic             pending
);
    always_comb begin
        pending = 1'b1;
        if (ien[2] && (stat.oe || stat.pe || stat.fe || stat.bi)) ident = ID_LINE;
        else if (ien[0] && stat.dr)                                ident = ID_RXD;
        else if (ien[1] && thr_empty)                              ident = ID_THR;
        else if (ien[3] && (|modem_delta))                         ident = ID_MODEM;
        else begin
            ident   = ID_NONE;
            pending = 1'b0;
        end
    end
endmodule

// File: rtl/serial_ctrl_front.sv
module serial_ctrl_front
    import scf_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned DIV_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    input  logic               rx_valid,
    input  logic [BYTE_W-1:0]  rx_byte,
    output logic               rx_ready,
    input  logic               rx_parity_err,
    input  logic               rx_frame_err,
    input  logic               rx_break,
    input  logic [MLINE_W-1:0] modem_lines,
    output logic               tx_valid,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic [LCTL_W-1:0]  line_ctrl,
    output logic [MCTL_W-1:0]  modem_ctrl,
    output logic [DIV_W-1:0]   divisor,
    output logic               irq
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [IEN_W-1:0]  ien;
        logic [LCTL_W-1:0] lctl;
        logic [MCTL_W-1:0] mctl;
        logic [DIV_W-1:0]  div;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              txv;
        logic [BYTE_W-1:0] txd;
        logic              irq;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0]  idx;
    logic              in_map;
    reg_sel_e          sel;
    logic              rd_hit, wr_hit;
    logic [BYTE_W-1:0] hold;
    rx_stat_t          rx_stat;
    logic [ID_W-1:0]   ident;
    logic              pending;
    logic [6:0]        lstat;

    assign idx = req_addr[ADDR_W-1:2];
    assign sel = reg_sel_e'(idx[2:0]);

    generate
        if (IDX_W > 3) begin : g_upper
            assign in_map = ~|idx[IDX_W-1:3];
        end else begin : g_flat
            assign in_map = 1'b1;
        end
    endgenerate

    assign rd_hit = req_valid && !req_write && in_map;
    assign wr_hit = req_valid &&  req_write && in_map;

    scf_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .take_data (rd_hit && sel == RG_DATA),
        .take_stat (rd_hit && sel == RG_LSTAT),
        .pe_stb    (rx_parity_err),
        .fe_stb    (rx_frame_err),
        .bi_stb    (rx_break),
        .hold_o    (hold),
        .stat_o    (rx_stat)
    );

    // transmit side never backs up: holding and shifter are always empty
    scf_irq_prio u_prio (
        .ien         (r_q.ien),
        .stat        (rx_stat),
        .thr_empty   (1'b1),
        .modem_delta (modem_lines[3:0]),
        .ident       (ident),
        .pending     (pending)
    );

    assign lstat = {1'b1, 1'b1, rx_stat.bi, rx_stat.fe, rx_stat.pe, rx_stat.oe, rx_stat.dr};

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = req_valid && !req_write;
        r_d.rdata  = '0;
        r_d.txv    = wr_hit && sel == RG_DATA;
        r_d.txd    = req_wdata[BYTE_W-1:0];
        r_d.irq    = pending;
        if (rd_hit) begin
            case (sel)
                RG_DATA:  r_d.rdata = DATA_W'(hold);
                RG_IDENT: r_d.rdata = DATA_W'(ident);
                RG_LSTAT: r_d.rdata = DATA_W'(lstat);
                RG_MSTAT: r_d.rdata = DATA_W'(modem_lines);
                default:  r_d.rdata = '0;
            endcase
        end
        if (wr_hit) begin
            case (sel)
                RG_IEN:  r_d.ien  = req_wdata[IEN_W-1:0];
                RG_LCTL: r_d.lctl = req_wdata[LCTL_W-1:0];
                RG_MCTL: r_d.mctl = req_wdata[MCTL_W-1:0];
                RG_DIV:  r_d.div  = req_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    logic unused_bits;
    assign unused_bits = ^{req_addr[1:0], req_wdata[DATA_W-1:DIV_W], modem_lines[MLINE_W-1:4]};

    assign rsp_valid  = r_q.rvalid;
    assign rsp_rdata  = r_q.rdata;
    assign tx_valid   = r_q.txv;
    assign tx_byte    = r_q.txd;
    assign line_ctrl  = r_q.lctl;
    assign modem_ctrl = r_q.mctl;
    assign divisor    = r_q.div;
    assign irq        = r_q.irq;
    assign rx_ready   = !rx_stat.dr;
endmodule

// File: rtl/scf_chk.sv
module scf_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              ovr_flag
);
    logic data_wr, data_rd;
    assign data_wr = req_valid &&  req_write && req_addr[ADDR_W-1:2] == '0;
    assign data_rd = req_valid && !req_write && req_addr[ADDR_W-1:2] == '0;

    AST_TX_ON_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (tx_valid && tx_byte == $past(req_wdata[BYTE_W-1:0]))); // R8
    AST_TX_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> !tx_valid); // R8
    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R11
    AST_ARRIVAL_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_ready); // R3
    AST_DATA_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_valid) |=> rx_ready); // R3
    AST_OVERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !data_rd) |=> ovr_flag); // R4
endmodule

bind serial_ctrl_front scf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .ovr_flag  (rx_stat.oe)
);

// File: tb/test_serial_ctrl_front.sv
`timescale 1ns/1ps
module test_serial_ctrl_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready;
    logic        rx_parity_err = 1'b0, rx_frame_err = 1'b0, rx_break = 1'b0;
    logic [7:0]  modem_lines = '0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic [7:0]  line_ctrl;
    logic [1:0]  modem_ctrl;
    logic [15:0] divisor;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 1'b0, run_cmp = 1'b0;

    always #2 clk = ~clk;

    serial_ctrl_front i_serial_ctrl_front (.*);

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_hold, m_lcr, m_div_lo, m_div_hi;
    logic        m_dr, m_oe, m_pe, m_fe, m_bi;
    logic [3:0]  m_ier;
    logic [1:0]  m_mcr;
    logic        m_rvalid, m_txv, m_irq;
    logic [31:0] m_rdata;
    logic [7:0]  m_txd;

    function automatic logic [2:0] ident_of(logic [3:0] ier, logic dr, logic errs, logic [3:0] md);
        if (ier[2] && errs)      return 3'b110;
        if (ier[0] && dr)        return 3'b100;
        if (ier[1])              return 3'b010;
        if (ier[3] && md != 0)   return 3'b000;
        return 3'b001;
    endfunction

    always @(posedge clk) begin : model
        int idx;
        logic rd, wr, ndr, noe, npe, nfe, nbi;
        logic [2:0] id;
        if (!rst_n) begin
            m_hold <= 0; m_lcr <= 0; m_div_lo <= 0; m_div_hi <= 0;
            {m_dr, m_oe, m_pe, m_fe, m_bi} <= 0;
            m_ier <= 0; m_mcr <= 0; m_rvalid <= 0; m_txv <= 0; m_irq <= 0;
            m_rdata <= 0; m_txd <= 0;
        end else begin
            idx = int'(req_addr) / 4;
            rd = req_valid && !req_write;
            wr = req_valid && req_write;
            id = ident_of(m_ier, m_dr, m_oe | m_pe | m_fe | m_bi, modem_lines[3:0]);
            m_irq    <= (id != 3'b001);
            m_rvalid <= rd;
            m_txv    <= wr && idx == 0;
            m_txd    <= req_wdata[7:0];
            case (idx)
                0: m_rdata <= {24'd0, m_hold};
                2: m_rdata <= {29'd0, id};
                5: m_rdata <= {25'd0, 1'b1, 1'b1, m_bi, m_fe, m_pe, m_oe, m_dr};
                6: m_rdata <= {24'd0, modem_lines};
                default: m_rdata <= 0;
            endcase
            if (wr && idx == 1) m_ier <= req_wdata[3:0];
            if (wr && idx == 3) m_lcr <= req_wdata[7:0];
            if (wr && idx == 4) m_mcr <= req_wdata[1:0];
            if (wr && idx == 7) begin m_div_lo <= req_wdata[7:0]; m_div_hi <= req_wdata[15:8]; end
            ndr = m_dr; noe = m_oe; npe = m_pe; nfe = m_fe; nbi = m_bi;
            if (rd && idx == 0) ndr = 1'b0;
            if (rd && idx == 5) begin noe = 0; npe = 0; nfe = 0; nbi = 0; end
            if (rx_valid) begin
                if (m_dr && !(rd && idx == 0)) noe = 1'b1;
                ndr = 1'b1;
                m_hold <= rx_byte;
            end
            if (rx_parity_err) npe = 1'b1;
            if (rx_frame_err)  nfe = 1'b1;
            if (rx_break)      nbi = 1'b1;
            {m_dr, m_oe, m_pe, m_fe, m_bi} <= {ndr, noe, npe, nfe, nbi};
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run_cmp) begin
            check("R3 rx_ready model", 32'(rx_ready), 32'(!m_dr));
            check("R7 irq model", 32'(irq), 32'(m_irq));
            check("R11 rsp_valid model", 32'(rsp_valid), 32'(m_rvalid));
            if (m_rvalid) check("R1 rsp_rdata model", rsp_rdata, m_rdata);
            check("R8 tx_valid model", 32'(tx_valid), 32'(m_txv));
            if (m_txv) check("R8 tx_byte model", 32'(tx_byte), 32'(m_txd));
            check("R9 config model", {6'd0, modem_ctrl, line_ctrl, divisor},
                  {6'd0, m_mcr, m_lcr, m_div_hi, m_div_lo});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        check(tag, rsp_rdata, exp);
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_byte = b;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        run_cmp = 1;
        idle(1);
        // R2 reset state
        check("R2 irq after reset", 32'(irq), 0);
        check("R2 rx_ready after reset", 32'(rx_ready), 1);
        check("R2 tx_valid after reset", 32'(tx_valid), 0);
        check("R2 config after reset", {line_ctrl, modem_ctrl, divisor}, 0);
        bus_rd(8'h14, 32'h60, "R2 line status reset");
        bus_rd(8'h08, 32'h1, "R2 ident reset");

        // R9 / R1 configuration and access rules
        bus_wr(8'h0C, 32'hFFFF_FFAB);
        bus_wr(8'h10, 32'h3);
        bus_wr(8'h1C, 32'hDEAD_1234);
        check("R9 line_ctrl", 32'(line_ctrl), 32'hAB);
        check("R9 modem_ctrl", 32'(modem_ctrl), 32'h3);
        check("R9 divisor", 32'(divisor), 32'h1234);
        bus_rd(8'h0C, 0, "R1 line control reads zero");
        bus_rd(8'h10, 0, "R1 modem control reads zero");
        bus_rd(8'h1C, 0, "R1 divisor reads zero");
        bus_rd(8'h04, 0, "R1 enable reads zero");
        bus_wr(8'h14, 32'h0);
        bus_wr(8'h28, 32'hFF);
        bus_rd(8'h14, 32'h60, "R1 line status write ignored");
        bus_rd(8'h24, 0, "R1 unmapped reads zero");
        check("R1 unmapped write ignored", {line_ctrl, modem_ctrl, divisor}, {8'hAB, 2'h3, 16'h1234});

        // R8 transmit
        bus_wr(8'h00, 32'h0000_01A5);
        check("R8 tx strobe", 32'(tx_valid), 1);
        check("R8 tx byte", 32'(tx_byte), 32'hA5);
        idle(1);
        check("R8 tx one cycle", 32'(tx_valid), 0);

        // R3 receive path
        rx_send(8'h3C);
        check("R3 ready low with data", 32'(rx_ready), 0);
        bus_rd(8'h14, 32'h61, "R5 data ready bit");
        bus_rd(8'h00, 32'h3C, "R3 held byte");
        check("R3 ready after read", 32'(rx_ready), 1);
        bus_rd(8'h14, 32'h60, "R3 data ready cleared");

        // R4 overrun
        rx_send(8'h11);
        rx_send(8'h22);
        bus_rd(8'h14, 32'h63, "R4 overrun set");
        bus_rd(8'h14, 32'h61, "R5 overrun cleared by read");
        bus_rd(8'h00, 32'h22, "R4 newest byte kept");

        // R5 sticky error strobes
        @(negedge clk); rx_parity_err = 1;
        @(negedge clk); rx_parity_err = 0; rx_frame_err = 1;
        @(negedge clk); rx_frame_err = 0; rx_break = 1;
        @(negedge clk); rx_break = 0;
        idle(2);
        bus_rd(8'h14, 32'h7C, "R5 sticky errors");
        bus_rd(8'h14, 32'h60, "R5 errors cleared");

        // R6 / R7 priority
        bus_wr(8'h04, 32'hF);
        bus_rd(8'h08, 32'h2, "R6 transmit empty ident");
        check("R7 irq for transmit empty", 32'(irq), 1);
        rx_send(8'h77);
        bus_rd(8'h08, 32'h4, "R6 receive data ident");
        @(negedge clk); rx_parity_err = 1;
        @(negedge clk); rx_parity_err = 0;
        bus_rd(8'h08, 32'h6, "R6 line status ident");
        bus_rd(8'h14, 32'h65, "R5 parity with data");
        bus_rd(8'h08, 32'h4, "R6 back to receive ident");
        bus_rd(8'h00, 32'h77, "R3 byte under interrupt");
        bus_rd(8'h08, 32'h2, "R6 back to transmit ident");
        bus_wr(8'h04, 32'h8);
        modem_lines = 8'h01;
        idle(2);
        bus_rd(8'h08, 32'h0, "R6 modem ident");
        check("R7 irq for modem", 32'(irq), 1);
        modem_lines = 8'h10;
        idle(2);
        check("R10 level bits give no irq", 32'(irq), 0);
        bus_rd(8'h08, 32'h1, "R10 ident none for level bits");
        bus_rd(8'h18, 32'h10, "R10 modem lines read");
        modem_lines = 8'h00;

        // R4 read and arrival in one cycle
        rx_send(8'h55);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 8'h00; rx_valid = 1; rx_byte = 8'h66;
        @(negedge clk);
        req_valid = 0; rx_valid = 0;
        check("R4 same-cycle read returns old", rsp_rdata, 32'h55);
        bus_rd(8'h14, 32'h61, "R4 no overrun on same-cycle read");
        bus_rd(8'h00, 32'h66, "R4 new byte stored");

        // R5 strobe during status read
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 8'h14; rx_parity_err = 1;
        @(negedge clk);
        req_valid = 0; rx_parity_err = 0;
        check("R5 read returns old status", rsp_rdata, 32'h60);
        bus_rd(8'h14, 32'h64, "R5 strobe wins over clear");
        bus_rd(8'h14, 32'h60, "R5 cleared afterwards");

        idle(3);
        done = 1;
        summary();
        $finish;
    end
endmodule